// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits next to a true dual-port memory and raises one interrupt flag for each of its two ports, called left and right. The two highest addresses of the shared array are reserved as message slots. The topmost address (all ones) belongs to the left port. The address one below it belongs to the right port. When one port writes a message into the other port's slot, the owner of that slot sees its interrupt go active. The owner then reads its slot, and that read drops the interrupt.

Each port runs on its own clock. The block watches the enables, the read/write strobe and the address of both ports. It registers each flag in the clock domain of the port that owns it. A write from the other side is carried across as a level toggle through a two-flop synchronizer, then turned back into a one-cycle set pulse. An asynchronous master reset forces both flags inactive.

Top module: `mbox_irq`

## Requirements
- R1: While `rst_n` is low, and after its release until a mailbox write arrives, both `lt_irq_n` and `rt_irq_n` are high (inactive).
- R2: A left-port write (`lt_we_n`=0) to the right slot (address all ones minus one) drives `rt_irq_n` low.
- R3: A right-port write (`rt_we_n`=0) to the left slot (address all ones) drives `lt_irq_n` low.
- R4: A read (`we_n`=1) by a port of its own slot returns that port's interrupt to high.
- R5: An access counts only when its `sel_n` is 0 and its `sel` is 1 on that port's clock edge. With either enable inactive, the access has no effect.
- R6: A port writing its own slot, or reading the other port's slot, changes neither flag.
- R7: Writes to any address below the two slots change neither flag.
- R8: When a set and a clearing read reach a flag in the same cycle, the flag ends up active.
- R9: With both clocks equal, a cross-port write sampled at edge 0 leaves the target flag high after edge 2 and low after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous master reset, active low |
| lt_clk | input | 1 | Left port clock |
| lt_sel_n | input | 1 | Left port enable, active low |
| lt_sel | input | 1 | Left port enable, active high |
| lt_we_n | input | 1 | Left port strobe: 0 = write, 1 = read |
| lt_addr | input | AW | Left port address |
| rt_clk | input | 1 | Right port clock |
| rt_sel_n | input | 1 | Right port enable, active low |
| rt_sel | input | 1 | Right port enable, active high |
| rt_we_n | input | 1 | Right port strobe: 0 = write, 1 = read |
| rt_addr | input | AW | Right port address |
| lt_irq_n | output | 1 | Left port interrupt, active low |
| rt_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Cross writes in both directions show that each slot is decoded to the correct owner. Owner reads that follow those writes show that a read clears the flag. Accesses with one enable dropped, own-slot writes, peer-slot reads and writes to ordinary addresses are each applied to a raised flag and to a clear flag, so that a wrong decode is caught whichever way it errs. A read timed to land in the same cycle as the synchronized set separates set priority from clear priority. Sampling just before and just after the third edge pins the synchronizer depth.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int AW = 8
) (
  input  logic          rst_n,
  input  logic          lt_clk,
  input  logic          lt_sel_n,
  input  logic          lt_sel,
  input  logic          lt_we_n,
  input  logic [AW-1:0] lt_addr,
  input  logic          rt_clk,
  input  logic          rt_sel_n,
  input  logic          rt_sel,
  input  logic          rt_we_n,
  input  logic [AW-1:0] rt_addr,
  output logic          lt_irq_n,
  output logic          rt_irq_n
);

  localparam logic [AW-1:0] LT_SLOT = '1;
  localparam logic [AW-1:0] RT_SLOT = LT_SLOT - 1'b1;

  logic lt_on, rt_on;
  logic lt_post, rt_post, lt_take, rt_take;
  logic lt_tog, rt_tog;
  logic [2:0] lt_sync, rt_sync;
  logic lt_set, rt_set;
  logic lt_flag, rt_flag;

  assign lt_on   = ~lt_sel_n & lt_sel;
  assign rt_on   = ~rt_sel_n & rt_sel;
  assign lt_post = lt_on & ~lt_we_n & (lt_addr == RT_SLOT);
  assign rt_post = rt_on & ~rt_we_n & (rt_addr == LT_SLOT);
  assign lt_take = lt_on &  lt_we_n & (lt_addr == LT_SLOT);
  assign rt_take = rt_on &  rt_we_n & (rt_addr == RT_SLOT);

  always_ff @(posedge lt_clk or negedge rst_n)
    if (!rst_n) lt_tog <= 1'b0;
    else if (lt_post) lt_tog <= ~lt_tog;

  always_ff @(posedge rt_clk or negedge rst_n)
    if (!rst_n) rt_tog <= 1'b0;
    else if (rt_post) rt_tog <= ~rt_tog;

  always_ff @(posedge lt_clk or negedge rst_n)
    if (!rst_n) lt_sync <= '0;
    else lt_sync <= {lt_sync[1:0], rt_tog};

  always_ff @(posedge rt_clk or negedge rst_n)
    if (!rst_n) rt_sync <= '0;
    else rt_sync <= {rt_sync[1:0], lt_tog};

  assign lt_set = lt_sync[1] ^ lt_sync[2];
  assign rt_set = rt_sync[1] ^ rt_sync[2];

  always_ff @(posedge lt_clk or negedge rst_n)
    if (!rst_n) lt_flag <= 1'b0;
    else if (lt_set) lt_flag <= 1'b1;
    else if (lt_take) lt_flag <= 1'b0;

  always_ff @(posedge rt_clk or negedge rst_n)
    if (!rst_n) rt_flag <= 1'b0;
    else if (rt_set) rt_flag <= 1'b1;
    else if (rt_take) rt_flag <= 1'b0;

  assign lt_irq_n = ~lt_flag;
  assign rt_irq_n = ~rt_flag;

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int AW = 8
) (
  input logic          rst_n,
  input logic          lt_clk,
  input logic          lt_sel_n,
  input logic          lt_sel,
  input logic          lt_we_n,
  input logic [AW-1:0] lt_addr,
  input logic          rt_clk,
  input logic          rt_sel_n,
  input logic          rt_sel,
  input logic          rt_we_n,
  input logic [AW-1:0] rt_addr,
  input logic          lt_irq_n,
  input logic          rt_irq_n,
  input logic [2:0]    lt_sync,
  input logic [2:0]    rt_sync
);
  localparam logic [AW-1:0] LT_SLOT = '1;
  localparam logic [AW-1:0] RT_SLOT = LT_SLOT - 1'b1;

  AST_LT_CLEAR_BY_OWN_READ: assert property (@(posedge lt_clk) disable iff (!rst_n)
    $rose(lt_irq_n) |-> $past(!lt_sel_n && lt_sel && lt_we_n && lt_addr == LT_SLOT)); // R4
  AST_RT_CLEAR_BY_OWN_READ: assert property (@(posedge rt_clk) disable iff (!rst_n)
    $rose(rt_irq_n) |-> $past(!rt_sel_n && rt_sel && rt_we_n && rt_addr == RT_SLOT)); // R4
  AST_LT_RAISE_FROM_SYNC: assert property (@(posedge lt_clk) disable iff (!rst_n)
    $fell(lt_irq_n) |-> $past(lt_sync[1] != lt_sync[2])); // R3
  AST_RT_RAISE_FROM_SYNC: assert property (@(posedge rt_clk) disable iff (!rst_n)
    $fell(rt_irq_n) |-> $past(rt_sync[1] != rt_sync[2])); // R2
  AST_LT_SET_WINS: assert property (@(posedge lt_clk) disable iff (!rst_n)
    (lt_sync[1] != lt_sync[2]) |=> !lt_irq_n); // R8
  AST_RT_SET_WINS: assert property (@(posedge rt_clk) disable iff (!rst_n)
    (rt_sync[1] != rt_sync[2]) |=> !rt_irq_n); // R8
endmodule

bind mbox_irq mbox_irq_chk #(.AW(AW)) u_chk (
  .rst_n(rst_n), .lt_clk(lt_clk), .lt_sel_n(lt_sel_n), .lt_sel(lt_sel),
  .lt_we_n(lt_we_n), .lt_addr(lt_addr), .rt_clk(rt_clk), .rt_sel_n(rt_sel_n),
  .rt_sel(rt_sel), .rt_we_n(rt_we_n), .rt_addr(rt_addr), .lt_irq_n(lt_irq_n),
  .rt_irq_n(rt_irq_n), .lt_sync(lt_sync), .rt_sync(rt_sync)
);

// File: tb/mbox_irq_test.sv
module mbox_irq_test;
  localparam int AW = 8;
  localparam logic [AW-1:0] LT_SLOT = 8'hFF;
  localparam logic [AW-1:0] RT_SLOT = 8'hFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lt_sel_n = 1'b1, lt_sel = 1'b0, lt_we_n = 1'b1;
  logic rt_sel_n = 1'b1, rt_sel = 1'b0, rt_we_n = 1'b1;
  logic [AW-1:0] lt_addr = '0, rt_addr = '0;
  logic lt_irq_n, rt_irq_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mbox_irq #(.AW(AW)) uut (
    .rst_n(rst_n), .lt_clk(clk), .lt_sel_n(lt_sel_n), .lt_sel(lt_sel),
    .lt_we_n(lt_we_n), .lt_addr(lt_addr), .rt_clk(clk), .rt_sel_n(rt_sel_n),
    .rt_sel(rt_sel), .rt_we_n(rt_we_n), .rt_addr(rt_addr),
    .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic lt_op(input logic we_n, input logic [AW-1:0] a,
                       input logic s_n = 1'b0, input logic s = 1'b1);
    lt_sel_n = s_n; lt_sel = s; lt_we_n = we_n; lt_addr = a;
    @(negedge clk);
    lt_sel_n = 1'b1; lt_sel = 1'b0; lt_we_n = 1'b1; lt_addr = '0;
  endtask

  task automatic rt_op(input logic we_n, input logic [AW-1:0] a,
                       input logic s_n = 1'b0, input logic s = 1'b1);
    rt_sel_n = s_n; rt_sel = s; rt_we_n = we_n; rt_addr = a;
    @(negedge clk);
    rt_sel_n = 1'b1; rt_sel = 1'b0; rt_we_n = 1'b1; rt_addr = '0;
  endtask

  task automatic t_reset;
    tick(2);
    chk("R1 lt in reset", lt_irq_n, 1'b1);
    chk("R1 rt in reset", rt_irq_n, 1'b1);
    rst_n = 1'b1;
    tick(3);
    chk("R1 lt after reset", lt_irq_n, 1'b1);
    chk("R1 rt after reset", rt_irq_n, 1'b1);
  endtask

  task automatic t_latency_and_clear;
    lt_op(1'b0, RT_SLOT);
    tick(2);
    chk("R9 rt still high after edge 2", rt_irq_n, 1'b1);
    tick(1);
    chk("R2 rt low after edge 3", rt_irq_n, 1'b0);
    chk("R2 lt untouched", lt_irq_n, 1'b1);
    rt_op(1'b1, RT_SLOT);
    chk("R4 rt cleared by own read", rt_irq_n, 1'b1);
    rt_op(1'b0, LT_SLOT);
    tick(4);
    chk("R3 lt low", lt_irq_n, 1'b0);
    chk("R3 rt untouched", rt_irq_n, 1'b1);
    lt_op(1'b1, LT_SLOT);
    chk("R4 lt cleared by own read", lt_irq_n, 1'b1);
  endtask

  task automatic t_enables;
    lt_op(1'b0, RT_SLOT, 1'b1, 1'b1);
    tick(4);
    chk("R5 sel_n high blocks set", rt_irq_n, 1'b1);
    lt_op(1'b0, RT_SLOT, 1'b0, 1'b0);
    tick(4);
    chk("R5 sel low blocks set", rt_irq_n, 1'b1);
    rt_op(1'b0, LT_SLOT);
    tick(4);
    lt_op(1'b1, LT_SLOT, 1'b1, 1'b1);
    chk("R5 sel_n high blocks clear", lt_irq_n, 1'b0);
    lt_op(1'b1, LT_SLOT, 1'b0, 1'b0);
    chk("R5 sel low blocks clear", lt_irq_n, 1'b0);
  endtask

  task automatic t_wrong_slot;
    lt_op(1'b0, LT_SLOT);
    tick(4);
    chk("R6 own-slot write keeps lt", lt_irq_n, 1'b0);
    chk("R6 own-slot write keeps rt", rt_irq_n, 1'b1);
    lt_op(1'b1, RT_SLOT);
    chk("R6 peer-slot read keeps lt", lt_irq_n, 1'b0);
    rt_op(1'b1, LT_SLOT);
    tick(1);
    chk("R6 rt peer-slot read keeps lt", lt_irq_n, 1'b0);
    lt_op(1'b1, LT_SLOT);
    chk("R4 lt cleared", lt_irq_n, 1'b1);
    rt_op(1'b0, RT_SLOT);
    tick(4);
    chk("R6 rt own-slot write", rt_irq_n, 1'b1);
    chk("R6 rt own-slot write lt", lt_irq_n, 1'b1);
  endtask

  task automatic t_plain_addr;
    lt_op(1'b0, 8'h00);
    lt_op(1'b0, 8'hFD);
    rt_op(1'b0, 8'h7F);
    rt_op(1'b0, 8'hFD);
    tick(4);
    chk("R7 plain writes rt", rt_irq_n, 1'b1);
    chk("R7 plain writes lt", lt_irq_n, 1'b1);
  endtask

  task automatic t_collide;
    lt_op(1'b0, RT_SLOT);
    tick(2);
    rt_op(1'b1, RT_SLOT);
    chk("R8 rt set wins over read", rt_irq_n, 1'b0);
    rt_op(1'b1, RT_SLOT);
    chk("R4 rt later read clears", rt_irq_n, 1'b1);
    rt_op(1'b0, LT_SLOT);
    tick(2);
    lt_op(1'b1, LT_SLOT);
    chk("R8 lt set wins over read", lt_irq_n, 1'b0);
    lt_op(1'b1, LT_SLOT);
    chk("R4 lt later read clears", lt_irq_n, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_latency_and_clear();
    t_enables();
    t_wrong_slot();
    t_plain_addr();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule